// File: doc/BRIEF.md
# Cycle Counter with Compare Timers

This block holds a 32-bit cycle counter that advances every clock by a step amount, plus up to three 32-bit compare registers. In normal operation the step is 1. On each advance every comparator checks, on its own, whether the counter has reached its compare value. The check is made in modular arithmetic over the advance window, so a target is still caught when the counter wraps past zero or jumps by more than one. A comparator that matches sets a sticky timer request. That request drives the interrupt request line chosen for that comparator by a parameter.

Software reaches the counter and the compare registers through a plain register write port and a combinational read port. A global timer-enable input turns all matching on or off. A wake-target output gives the compare value that the counter will reach first. A sleep controller can use it to plan the next wake-up. Interrupt prioritization and halt-mode clocking are handled elsewhere.

Top module: `cyc_cmp_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and all compare registers become 0 and all `irq_o` lines are 0 after that edge.
- R2: On a clock edge with no counter write, the counter becomes (counter + `step`) modulo 2^32.
- R3: A write with `wr_addr` = 0 loads `wr_data` into the counter, and the loaded value is visible after that edge. No comparator can set its request on that cycle.
- R4: With `tmr_en` high and no register write, comparator k sets its request at the edge when (compare_k − counter_before) modulo 2^32 ≤ `step`. This includes windows that cross the wrap from 0xFFFFFFFF to 0.
- R5: With `tmr_en` low, no comparator sets its request, whatever the counter and compare values are.
- R6: A request that has been set stays set while the counter keeps advancing and other registers are written. It clears only when its own compare register is written or reset occurs.
- R7: A write to compare register k (`wr_addr` = k+1) clears request k at that edge. The write wins over a match on the same cycle.
- R8: Request k drives bit IRQ_MAP[k*IDX_W +: IDX_W] of `irq_o`. With the defaults, comparators 0, 1 and 2 drive lines 1, 5 and 2. Lines that no set request maps to are 0.
- R9: `wake_o` is the compare value with the smallest forward distance (compare − counter) modulo 2^32. If no compare value is closer, it is counter − 1.
- R10: `rd_data` returns the counter for `rd_addr` = 0, compare k for `rd_addr` = k+1, and 0 for any other address. Writes to those other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Global timer-match enable |
| step | input | STEP_W | Advance amount for this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 counter, k+1 compare k |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Read data (combinational) |
| irq_o | output | N_IRQ | Timer request lines |
| wake_o | output | CNT_W | Nearest compare target |

## Verification
The match rule is swept over six base counts, including both sides of the wrap and the sign boundary, four step sizes and eight compare offsets from −2 to +5. This separates an equality-only match, an off-by-one window and a signed compare from the correct modular test. The same sweep with the enable low shows that matching is gated. Directed patterns cover a counter load on a cycle that would match, a compare rewrite on a cycle that would match, and long runs after firing. Routing of several comparators to their request lines and wake targets around the wrap complete the checks.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_NONE = 2'd2
  } reg_sel_e;

  // forward distance from 'from' to 'to' modulo 2^W
  function automatic logic [63:0] fwd_dist(input logic [63:0] to, input logic [63:0] from,
                                           input int unsigned w);
    logic [63:0] mask;
    mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (to - from) & mask;
  endfunction
endpackage

// File: rtl/ctc_counter.sv
module ctc_counter #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] step_ext;
  assign step_ext = CNT_W'(step);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else           count <= count + step_ext;
  end
endmodule

// File: rtl/ctc_cmp_slot.sv
module ctc_cmp_slot #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              eval_en,
  input  logic [CNT_W-1:0]  old_cnt,
  input  logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              hit
);
  logic [CNT_W-1:0] gap;
  logic             in_window;

  // modular distance ahead of the pre-advance count
  assign gap       = cmp_val - old_cnt;
  assign in_window = (gap <= CNT_W'(step));

  always_ff @(posedge clk) begin
    if (rst)     cmp_val <= '0;
    else if (wr) cmp_val <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                       hit <= 1'b0;
    else if (wr)                   hit <= 1'b0;
    else if (eval_en && in_window) hit <= 1'b1;
  end
endmodule

// File: rtl/ctc_wake_sel.sv
module ctc_wake_sel #(
  parameter int CNT_W = 32,
  parameter int N_CMP = 3
) (
  input  logic [CNT_W-1:0]       cnt,
  input  logic [N_CMP*CNT_W-1:0] cmp_flat,
  output logic [CNT_W-1:0]       wake
);
  logic [CNT_W-1:0] best_d;
  logic [CNT_W-1:0] cand_d;

  always_comb begin
    wake   = cnt - CNT_W'(1);
    best_d = '1;
    cand_d = '0;
    for (int k = 0; k < N_CMP; k++) begin
      cand_d = cmp_flat[k*CNT_W +: CNT_W] - cnt;
      if (cand_d < best_d) begin
        best_d = cand_d;
        wake   = cmp_flat[k*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/ctc_irq_route.sv
module ctc_irq_route #(
  parameter int N_CMP = 3,
  parameter int N_IRQ = 8,
  parameter int IDX_W = 3,
  parameter logic [N_CMP*IDX_W-1:0] MAP = '0
) (
  input  logic [N_CMP-1:0] hits,
  output logic [N_IRQ-1:0] irq
);
  always_comb begin
    irq = '0;
    for (int k = 0; k < N_CMP; k++) begin
      if (hits[k]) irq[MAP[k*IDX_W +: IDX_W]] = 1'b1;
    end
  end
endmodule

// File: rtl/cyc_cmp_timer.sv
module cyc_cmp_timer #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 8,
  parameter int N_CMP  = 3,
  parameter int N_IRQ  = 8,
  parameter int ADDR_W = 3,
  parameter logic [N_CMP*$clog2(N_IRQ)-1:0] IRQ_MAP = 9'b010_101_001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmr_en,
  input  logic [STEP_W-1:0] step,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [N_IRQ-1:0]  irq_o,
  output logic [CNT_W-1:0]  wake_o
);
  import ctc_pkg::*;

  localparam int IDX_W = $clog2(N_IRQ);

  logic                   cnt_ld;
  logic [N_CMP-1:0]       cmp_wr;
  logic [CNT_W-1:0]       cnt_q;
  logic [N_CMP*CNT_W-1:0] cmp_flat;
  logic [N_CMP-1:0]       hit_q;
  logic                   eval_en;
  reg_sel_e               rd_sel;

  // write decode
  assign cnt_ld  = wr_en && (wr_addr == '0);
  assign eval_en = tmr_en && !cnt_ld;

  ctc_counter #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_ld),
    .load_val (wr_data),
    .step     (step),
    .count    (cnt_q)
  );

  for (genvar k = 0; k < N_CMP; k++) begin : g_slot
    assign cmp_wr[k] = wr_en && (wr_addr == ADDR_W'(k + 1));

    ctc_cmp_slot #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr      (cmp_wr[k]),
      .wdata   (wr_data),
      .eval_en (eval_en),
      .old_cnt (cnt_q),
      .step    (step),
      .cmp_val (cmp_flat[k*CNT_W +: CNT_W]),
      .hit     (hit_q[k])
    );
  end

  ctc_wake_sel #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_wake (
    .cnt      (cnt_q),
    .cmp_flat (cmp_flat),
    .wake     (wake_o)
  );

  ctc_irq_route #(.N_CMP(N_CMP), .N_IRQ(N_IRQ), .IDX_W(IDX_W), .MAP(IRQ_MAP)) u_route (
    .hits (hit_q),
    .irq  (irq_o)
  );

  // read path
  always_comb begin
    if (rd_addr == '0)                              rd_sel = SEL_CNT;
    else if (32'(rd_addr) <= N_CMP)                 rd_sel = SEL_CMP;
    else                                            rd_sel = SEL_NONE;
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CNT: rd_data = cnt_q;
      SEL_CMP: begin
        for (int k = 0; k < N_CMP; k++) begin
          if (rd_addr == ADDR_W'(k + 1)) rd_data = cmp_flat[k*CNT_W +: CNT_W];
        end
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ctc_timer_chk.sv
module ctc_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 8,
  parameter int N_CMP  = 3,
  parameter int N_IRQ  = 8,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 3,
  parameter logic [N_CMP*IDX_W-1:0] MAP = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tmr_en,
  input logic [STEP_W-1:0]      step,
  input logic [CNT_W-1:0]       wr_data,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic [CNT_W-1:0]       rd_data,
  input logic [N_IRQ-1:0]       irq_o,
  input logic [CNT_W-1:0]       wake_o,
  input logic                   cnt_ld,
  input logic [N_CMP-1:0]       cmp_wr,
  input logic [CNT_W-1:0]       cnt_q,
  input logic [N_CMP*CNT_W-1:0] cmp_flat,
  input logic [N_CMP-1:0]       hit_q
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && hit_q == '0 && irq_o == '0));

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    !cnt_ld |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'($past(step))));

  p_count_load_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_ld |=> cnt_q == $past(wr_data));

  p_no_match_on_load_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_ld |=> hit_q == $past(hit_q));

  p_read_count_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == '0) |-> rd_data == cnt_q);

  for (genvar k = 0; k < N_CMP; k++) begin : g_chk
    localparam int LINE = int'(MAP[k*IDX_W +: IDX_W]);

    p_gated_off_r5: assert property (@(posedge clk) disable iff (rst)
      (!tmr_en && !hit_q[k]) |=> !hit_q[k]);

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (hit_q[k] && !cmp_wr[k]) |=> hit_q[k]);

    p_write_clears_r7: assert property (@(posedge clk) disable iff (rst)
      cmp_wr[k] |=> !hit_q[k]);

    p_routed_r8: assert property (@(posedge clk) disable iff (rst)
      hit_q[k] |-> irq_o[LINE]);

    p_wake_nearest_r9: assert property (@(posedge clk) disable iff (rst)
      CNT_W'(wake_o - cnt_q) <= CNT_W'(cmp_flat[k*CNT_W +: CNT_W] - cnt_q));
  end
endmodule

bind cyc_cmp_timer ctc_timer_chk #(
  .CNT_W(CNT_W), .STEP_W(STEP_W), .N_CMP(N_CMP), .N_IRQ(N_IRQ),
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .MAP(IRQ_MAP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tmr_en   (tmr_en),
  .step     (step),
  .wr_data  (wr_data),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .irq_o    (irq_o),
  .wake_o   (wake_o),
  .cnt_ld   (cnt_ld),
  .cmp_wr   (cmp_wr),
  .cnt_q    (cnt_q),
  .cmp_flat (cmp_flat),
  .hit_q    (hit_q)
);

// File: tb/test_cyc_cmp_timer.sv
module test_cyc_cmp_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tmr_en = 1'b0;
  logic [7:0]  step = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  irq_o;
  logic [31:0] wake_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cyc_cmp_timer i_cyc_cmp_timer (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .step(step),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] bases [6];
    bases[0] = 32'h0000_0000; bases[1] = 32'h0000_0001; bases[2] = 32'h7FFF_FFFF;
    bases[3] = 32'hFFFF_FFFE; bases[4] = 32'hFFFF_FFFF; bases[5] = 32'h1234_5678;

    repeat (3) tick();
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), v);
      check("R1 reg after reset", v, 32'h0);
    end
    check("R1 irq after reset", {24'h0, irq_o}, 32'h0);
    check("R9 wake at reset (distance 0)", wake_o, 32'h0);

    // R2: plain advance, step 1 then step 7
    wr(3'd0, 32'hFFFF_FFFA);
    step = 8'd1;
    repeat (10) tick();
    step = 8'd0;
    rd(3'd0, v);
    check("R2 count step 1 across wrap", v, 32'h0000_0004);
    step = 8'd7;
    repeat (5) tick();
    step = 8'd0;
    rd(3'd0, v);
    check("R2 count step 7", v, 32'h0000_0027);

    // R4 / R2: sweep of the modular window
    for (int bi = 0; bi < 6; bi++) begin
      for (int d = 0; d < 4; d++) begin
        for (int off = -2; off <= 5; off++) begin
          logic [31:0] b, c;
          b = bases[bi];
          c = b + 32'(off);
          wr(3'd1, c);
          wr(3'd0, b);
          tmr_en = 1'b1; step = 8'(d);
          tick();
          tmr_en = 1'b0; step = 8'd0;
          check("R4 match window", {31'h0, irq_o[1]}, {31'h0, (off >= 0 && off <= d)});
          rd(3'd0, v);
          check("R2 count after step", v, b + 32'(d));
        end
      end
    end

    // R5: enable low, values that would match
    for (int d = 0; d < 4; d++) begin
      for (int off = 0; off <= d; off++) begin
        wr(3'd1, 32'h0000_1000 + 32'(off));
        wr(3'd0, 32'h0000_1000);
        step = 8'(d);
        tick();
        step = 8'd0;
        check("R5 no match with enable low", {31'h0, irq_o[1]}, 32'h0);
      end
    end

    // R3: counter load on a cycle that would match
    wr(3'd1, 32'd100);
    wr(3'd0, 32'd100);
    tmr_en = 1'b1; step = 8'd1;
    wr(3'd0, 32'd5000);
    tmr_en = 1'b0; step = 8'd0;
    check("R3 no match on load cycle", {31'h0, irq_o[1]}, 32'h0);
    rd(3'd0, v);
    check("R3 loaded value", v, 32'd5000);

    // R6: sticky request
    wr(3'd1, 32'd50);
    wr(3'd0, 32'd49);
    tmr_en = 1'b1; step = 8'd1;
    tick();
    check("R6 fired", {31'h0, irq_o[1]}, 32'h1);
    for (int i = 0; i < 20; i++) begin
      tick();
      check("R6 held while advancing", {31'h0, irq_o[1]}, 32'h1);
    end
    wr(3'd2, 32'hA000_0000);
    check("R6 held over other compare write", {31'h0, irq_o[1]}, 32'h1);
    tmr_en = 1'b0; step = 8'd0;

    // R7: rewrite clears, write beats a same-cycle match
    wr(3'd1, 32'h9000_0000);
    check("R7 rewrite clears", {31'h0, irq_o[1]}, 32'h0);
    wr(3'd0, 32'd299);
    wr(3'd1, 32'd300);
    tmr_en = 1'b1; step = 8'd1;
    wr(3'd1, 32'd300);
    check("R7 write wins over match", {31'h0, irq_o[1]}, 32'h0);
    tick();
    check("R7 fires on following cycle", {31'h0, irq_o[1]}, 32'h1);
    tmr_en = 1'b0; step = 8'd0;

    // R8: routing of comparators 1 and 2
    wr(3'd1, 32'h8000_0000);
    wr(3'd2, 32'd1001);
    wr(3'd3, 32'h7000_0000);
    wr(3'd0, 32'd1000);
    tmr_en = 1'b1; step = 8'd1;
    tick();
    tmr_en = 1'b0; step = 8'd0;
    check("R8 comparator 1 on line 5 only", {24'h0, irq_o}, 32'h0000_0020);
    wr(3'd3, 32'd1002);
    tmr_en = 1'b1; step = 8'd1;
    tick();
    tmr_en = 1'b0; step = 8'd0;
    check("R8 comparators 1,2 on lines 5,2", {24'h0, irq_o}, 32'h0000_0024);

    // R10: read map and ignored addresses
    rd(3'd1, v); check("R10 read cmp0", v, 32'h8000_0000);
    rd(3'd2, v); check("R10 read cmp1", v, 32'd1001);
    rd(3'd3, v); check("R10 read cmp2", v, 32'd1002);
    wr(3'd5, 32'hDEAD_BEEF);
    for (int a = 4; a < 8; a++) begin
      rd(3'(a), v);
      check("R10 unmapped read 0", v, 32'h0);
    end
    rd(3'd0, v); check("R10 count untouched by bad write", v, 32'd1002);
    rd(3'd1, v); check("R10 cmp0 untouched by bad write", v, 32'h8000_0000);
    check("R10 irq untouched by bad write", {24'h0, irq_o}, 32'h0000_0024);

    // R9: wake target
    wr(3'd1, 32'd1500);
    wr(3'd2, 32'd1200);
    wr(3'd3, 32'd900);
    wr(3'd0, 32'd1000);
    check("R9 nearest ahead", wake_o, 32'd1200);
    wr(3'd3, 32'd1000);
    check("R9 target equal to count", wake_o, 32'd1000);
    wr(3'd1, 32'h0000_0010);
    wr(3'd2, 32'hFFFF_FFF8);
    wr(3'd3, 32'h0000_0005);
    wr(3'd0, 32'hFFFF_FFF0);
    check("R9 nearest across wrap", wake_o, 32'hFFFF_FFF8);
    wr(3'd1, 32'hFFFF_FFEF);
    wr(3'd2, 32'hFFFF_FFEF);
    wr(3'd3, 32'hFFFF_FFEF);
    check("R9 default count-1", wake_o, 32'hFFFF_FFEF);

    done = 1;
    summary();
    $finish;
  end
endmodule